// File: doc/BRIEF.md
# Load-Pair Decode and Address Sequencer

This block accepts one 32-bit load-pair instruction word together with the current value of its base register. It pulls apart the register numbers, the element size, the signedness and the addressing mode. It then drives a single read port for two consecutive element accesses and reports the value the base register should take after the pair. Formatting of the loaded data, register-file storage and fault handling beyond raising flags are left to neighbouring blocks.

An instruction is taken on a valid/ready handshake while the block is idle. The decoded fields and both access addresses are captured at that moment and held until the next instruction is taken. The two reads go out in order, with one outstanding at a time. After the second response the block pulses `done_o` for one cycle together with the writeback enable. An instruction with an illegal encoding issues no reads, and `done_o` pulses one cycle after acceptance with `illegal_o` set.

Top module: `pairload_unit`

## Requirements
- R1: `dst_first_o` holds instruction bits 4:0 and `dst_second_o` holds bits 14:10 of the accepted word. The base register number is bits 9:5.
- R2: The size code is the log2 of the element bytes, taken from opc (bits 31:30) and the vector flag (bit 26). In scalar form (bit 26 = 0), size = 2 + opc[1] and signed = opc[0]. In vector form, size = 2 + opc (4, 8 or 16 bytes) and signed = 0. `size_code_o` and `rd_size_o` both carry this code.
- R3: opc = 3 is illegal. The block raises `illegal_o`, issues no read, asserts no writeback and still pulses `done_o`.
- R4: The index mode is bits 25:23. 001 is post-index, 010 is signed offset and 011 is pre-index. Every other value is illegal and is handled as in R3.
- R5: The byte offset is the sign-extended imm7 (bits 21:15) shifted left by the size code. The first address is base + offset in pre-index and offset modes, and the base itself in post-index mode.
- R6: The second address is the first address plus 2^size bytes.
- R7: Writeback is enabled only in post-index and pre-index modes, with value base + offset. Signed-offset mode never writes back.
- R8: When bits 9:5 equal 31 on a legal instruction, `align_req_o` is raised.
- R9: `in_ready_o` is high only while idle, so a word presented while busy is not taken. The first read goes out before the second. Each request stays asserted with a stable address until `rd_ready_i` is high, and the second request waits for the first response.
- R10: `done_o` is high for exactly one cycle, after the second response. Writeback enable is valid in that cycle.
- R11: After reset the block is idle and ready, with no request, no done, no writeback, and illegal and alignment flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Block idle and able to take an instruction |
| in_insn_i | input | 32 | Load-pair instruction word |
| in_base_i | input | ADDR_W | Current base register value |
| rd_req_o | output | 1 | Read request |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read address |
| rd_size_o | output | 3 | Read size as log2 bytes |
| rd_resp_i | input | 1 | Read response for the outstanding request |
| dst_first_o | output | 5 | First destination register |
| dst_second_o | output | 5 | Second destination register |
| size_code_o | output | 3 | Element size as log2 bytes |
| is_vector_o | output | 1 | Vector-register form |
| is_signed_o | output | 1 | Sign-extending scalar form |
| addr_first_o | output | ADDR_W | First access address |
| addr_second_o | output | ADDR_W | Second access address |
| wb_en_o | output | 1 | Base writeback enable, valid with done |
| wb_value_o | output | ADDR_W | Base writeback value |
| align_req_o | output | 1 | Stack-pointer alignment check requested |
| illegal_o | output | 1 | Illegal encoding |
| done_o | output | 1 | Instruction complete, one-cycle pulse |

## Verification
A wrong size decode shows up at the first read request. The address is off by a whole element, or `rd_size_o` differs, in the cycle after acceptance. A corrupt sequencer state shows as a missing or duplicated request, as a second request before the first response, or as `done_o` arriving early or lasting two cycles, all visible within a few cycles of the bad transition. A bad writeback derivation stays hidden until `done_o`, where `wb_value_o` is compared against base + offset.

// File: rtl/pairload_pkg.sv
package pairload_pkg;
   localparam int INSN_W = 32;
   localparam int REG_W  = 5;
   localparam int IMM_W  = 7;
   localparam int SIZE_W = 3;

   typedef enum logic [1:0] {
      IDX_NONE   = 2'd0,
      IDX_POST   = 2'd1,
      IDX_OFFSET = 2'd2,
      IDX_PRE    = 2'd3
   } idx_mode_e;

   typedef struct packed {
      logic [REG_W-1:0]  dst_a;
      logic [REG_W-1:0]  dst_b;
      logic [REG_W-1:0]  base_reg;
      logic [IMM_W-1:0]  imm;
      logic [SIZE_W-1:0] size_code;
      logic              is_vec;
      logic              is_sgn;
      idx_mode_e         mode;
      logic              bad;
      logic              sp_base;
   } pair_dec_t;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ISSUE_A = 3'd1,
      ST_WAIT_A  = 3'd2,
      ST_ISSUE_B = 3'd3,
      ST_WAIT_B  = 3'd4,
      ST_DONE    = 3'd5
   } seq_state_e;
endpackage

// File: rtl/pairload_decode.sv
module pairload_decode
   import pairload_pkg::*;
(
   input  logic [INSN_W-1:0] insn_i,
   output pair_dec_t         dec_o
);
   localparam int RT_LSB   = 0;
   localparam int RN_LSB   = 5;
   localparam int RT2_LSB  = 10;
   localparam int IMM_LSB  = 15;
   localparam int IDX_LSB  = 23;
   localparam int VEC_BIT  = 26;
   localparam int OPC_LSB  = 30;
   localparam logic [REG_W-1:0] SP_NUM = REG_W'((1 << REG_W) - 1);

   logic [1:0] opc;
   logic [2:0] idx;
   logic       vec;
   logic       opc_bad;
   logic       idx_bad;
   idx_mode_e  mode;
   logic       unused_fixed;

   assign opc = insn_i[OPC_LSB +: 2];
   assign idx = insn_i[IDX_LSB +: 3];
   assign vec = insn_i[VEC_BIT];
   assign opc_bad = (opc == 2'd3);
   assign unused_fixed = ^{insn_i[29:27], insn_i[22]};

   always_comb begin
      idx_bad = 1'b0;
      unique case (idx)
         3'b001:  mode = IDX_POST;
         3'b010:  mode = IDX_OFFSET;
         3'b011:  mode = IDX_PRE;
         default: begin
            mode    = IDX_NONE;
            idx_bad = 1'b1;
         end
      endcase
   end

   always_comb begin
      dec_o          = '0;
      dec_o.dst_a    = insn_i[RT_LSB  +: REG_W];
      dec_o.dst_b    = insn_i[RT2_LSB +: REG_W];
      dec_o.base_reg = insn_i[RN_LSB  +: REG_W];
      dec_o.imm      = insn_i[IMM_LSB +: IMM_W];
      dec_o.is_vec   = vec;
      dec_o.mode     = mode;
      dec_o.bad      = opc_bad | idx_bad;
      dec_o.sp_base  = (insn_i[RN_LSB +: REG_W] == SP_NUM) & ~(opc_bad | idx_bad);
      if (vec) begin
         dec_o.is_sgn = 1'b0;
         unique case (opc)
            2'd0:    dec_o.size_code = 3'd2;
            2'd1:    dec_o.size_code = 3'd3;
            2'd2:    dec_o.size_code = 3'd4;
            default: dec_o.size_code = 3'd2;
         endcase
      end else begin
         dec_o.is_sgn    = opc[0] & ~opc_bad;
         dec_o.size_code = opc[1] & ~opc_bad ? 3'd3 : 3'd2;
      end
   end
endmodule

// File: rtl/pairload_addr.sv
module pairload_addr
   import pairload_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter bit WB_VIA_SECOND = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [SIZE_W-1:0] size_i,
   input  idx_mode_e         mode_i,
   output logic [ADDR_W-1:0] first_o,
   output logic [ADDR_W-1:0] second_o,
   output logic [ADDR_W-1:0] wb_o
);
   localparam int EXT_W = ADDR_W - IMM_W;

   generate
      if (ADDR_W < 16 || ADDR_W > 128) begin : g_bad_width
         $error("pairload_addr: ADDR_W must lie in 16..128");
      end
   endgenerate

   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] step;

   assign off      = {{EXT_W{imm_i[IMM_W-1]}}, imm_i} << size_i;
   assign step     = ADDR_W'(1) << size_i;
   assign first_o  = (mode_i == IDX_POST) ? base_i : base_i + off;
   assign second_o = first_o + step;

   generate
      if (WB_VIA_SECOND) begin : g_wb_chain
         always_comb begin
            if (mode_i == IDX_POST) wb_o = second_o + off - step;
            else                    wb_o = second_o - step;
         end
      end else begin : g_wb_direct
         assign wb_o = base_i + off;
      end
   endgenerate
endmodule

// File: rtl/pairload_ctrl.sv
module pairload_ctrl
   import pairload_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic start_bad_i,
   input  logic rd_ready_i,
   input  logic rd_resp_i,
   output logic in_ready_o,
   output logic rd_req_o,
   output logic phase_b_o,
   output logic done_o
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i)    state_d = start_bad_i ? ST_DONE : ST_ISSUE_A;
         ST_ISSUE_A: if (rd_ready_i) state_d = ST_WAIT_A;
         ST_WAIT_A:  if (rd_resp_i)  state_d = ST_ISSUE_B;
         ST_ISSUE_B: if (rd_ready_i) state_d = ST_WAIT_B;
         ST_WAIT_B:  if (rd_resp_i)  state_d = ST_DONE;
         ST_DONE:                    state_d = ST_IDLE;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign in_ready_o = (state_q == ST_IDLE);
   assign rd_req_o   = (state_q == ST_ISSUE_A) | (state_q == ST_ISSUE_B);
   assign phase_b_o  = (state_q == ST_ISSUE_B);
   assign done_o     = (state_q == ST_DONE);

   // R9: a pending request is not withdrawn before it is taken
   assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_o && !rd_ready_i) |=> rd_req_o);

   // R10: completion lasts a single cycle
   assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R11: an idle block is silent on the read port and completion
   assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o |-> (!rd_req_o && !done_o));
endmodule

// File: rtl/pairload_unit.sv
module pairload_unit
   import pairload_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter bit WB_VIA_SECOND = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   input  logic [31:0]       in_insn_i,
   input  logic [ADDR_W-1:0] in_base_i,
   output logic              rd_req_o,
   input  logic              rd_ready_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [2:0]        rd_size_o,
   input  logic              rd_resp_i,
   output logic [4:0]        dst_first_o,
   output logic [4:0]        dst_second_o,
   output logic [2:0]        size_code_o,
   output logic              is_vector_o,
   output logic              is_signed_o,
   output logic [ADDR_W-1:0] addr_first_o,
   output logic [ADDR_W-1:0] addr_second_o,
   output logic              wb_en_o,
   output logic [ADDR_W-1:0] wb_value_o,
   output logic              align_req_o,
   output logic              illegal_o,
   output logic              done_o
);
   generate
      if (INSN_W != 32 || REG_W != 5 || SIZE_W != 3) begin : g_bad_pkg
         $error("pairload_unit: package widths do not match the port list");
      end
   endgenerate

   pair_dec_t         dec_d, dec_q;
   logic [ADDR_W-1:0] first_d, second_d, wb_d;
   logic [ADDR_W-1:0] first_q, second_q, wb_q;
   logic              accept;
   logic              phase_b;
   logic              unused_dec;

   pairload_decode u_decode (
      .insn_i (in_insn_i),
      .dec_o  (dec_d)
   );

   pairload_addr #(
      .ADDR_W        (ADDR_W),
      .WB_VIA_SECOND (WB_VIA_SECOND)
   ) u_addr (
      .base_i   (in_base_i),
      .imm_i    (dec_d.imm),
      .size_i   (dec_d.size_code),
      .mode_i   (dec_d.mode),
      .first_o  (first_d),
      .second_o (second_d),
      .wb_o     (wb_d)
   );

   pairload_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (accept),
      .start_bad_i (dec_d.bad),
      .rd_ready_i  (rd_ready_i),
      .rd_resp_i   (rd_resp_i),
      .in_ready_o  (in_ready_o),
      .rd_req_o    (rd_req_o),
      .phase_b_o   (phase_b),
      .done_o      (done_o)
   );

   assign accept = in_valid_i & in_ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dec_q    <= '0;
         first_q  <= '0;
         second_q <= '0;
         wb_q     <= '0;
      end else if (accept) begin
         dec_q    <= dec_d;
         first_q  <= first_d;
         second_q <= second_d;
         wb_q     <= wb_d;
      end
   end

   assign unused_dec    = ^{dec_q.imm, dec_q.base_reg};
   assign rd_addr_o     = phase_b ? second_q : first_q;
   assign rd_size_o     = dec_q.size_code;
   assign dst_first_o   = dec_q.dst_a;
   assign dst_second_o  = dec_q.dst_b;
   assign size_code_o   = dec_q.size_code;
   assign is_vector_o   = dec_q.is_vec;
   assign is_signed_o   = dec_q.is_sgn;
   assign addr_first_o  = first_q;
   assign addr_second_o = second_q;
   assign wb_value_o    = wb_q;
   assign wb_en_o       = done_o & ~dec_q.bad & (dec_q.mode != IDX_OFFSET);
   assign align_req_o   = dec_q.sp_base;
   assign illegal_o     = dec_q.bad;

   // R3: an illegal word never reaches the read port
   assert_no_read_on_illegal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> !rd_req_o);

   // R6: second request lands one element above the first address
   assert_second_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_o && phase_b) |-> (rd_addr_o == first_q + (ADDR_W'(1) << rd_size_o)));

   // R2: any issued access has a size the encoding allows
   assert_size_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o |-> ((rd_size_o >= 3'd2) && (rd_size_o <= 3'd4)
                    && (is_vector_o || rd_size_o != 3'd4)
                    && (!is_signed_o || (!is_vector_o && rd_size_o == 3'd2))));

   // R9: address holds while the request waits
   assert_addr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_o && !rd_ready_i) |=> $stable(rd_addr_o));
endmodule

// File: tb/tb_pairload_unit.sv
`timescale 1ns/1ps
module tb_pairload_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_insn = '0;
   logic [63:0] in_base = '0;
   logic        rd_req;
   logic        rd_ready;
   logic [63:0] rd_addr;
   logic [2:0]  rd_size;
   logic        rd_resp;
   logic [4:0]  dst_first, dst_second;
   logic [2:0]  size_code;
   logic        is_vector, is_signed;
   logic [63:0] addr_first, addr_second, wb_value;
   logic        wb_en, align_req, illegal, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int mem_lat = 0;
   int rdy_dly = 0;
   int nseen = 0;
   logic [63:0] seen_addr [0:3];
   logic [2:0]  seen_size [0:3];

   always #4 clk = ~clk;

   pairload_unit dut (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
      .in_insn_i(in_insn), .in_base_i(in_base), .rd_req_o(rd_req), .rd_ready_i(rd_ready),
      .rd_addr_o(rd_addr), .rd_size_o(rd_size), .rd_resp_i(rd_resp),
      .dst_first_o(dst_first), .dst_second_o(dst_second), .size_code_o(size_code),
      .is_vector_o(is_vector), .is_signed_o(is_signed), .addr_first_o(addr_first),
      .addr_second_o(addr_second), .wb_en_o(wb_en), .wb_value_o(wb_value),
      .align_req_o(align_req), .illegal_o(illegal), .done_o(done)
   );

   // fields: opc, vec, mode, imm7, rt2, rn, rt, exp size, exp signed, exp illegal
   localparam logic [32:0] TBL [0:11] = '{
      {2'd0, 1'b0, 3'd2, 7'd5,   5'd2,  5'd3,  5'd1,  3'd2, 1'b0, 1'b0},
      {2'd1, 1'b0, 3'd3, 7'h7D,  5'd4,  5'd5,  5'd6,  3'd2, 1'b1, 1'b0},
      {2'd2, 1'b0, 3'd1, 7'd10,  5'd7,  5'd8,  5'd9,  3'd3, 1'b0, 1'b0},
      {2'd0, 1'b1, 3'd2, 7'd1,   5'd10, 5'd11, 5'd12, 3'd2, 1'b0, 1'b0},
      {2'd1, 1'b1, 3'd3, 7'h7F,  5'd13, 5'd14, 5'd15, 3'd3, 1'b0, 1'b0},
      {2'd2, 1'b1, 3'd1, 7'h40,  5'd16, 5'd17, 5'd18, 3'd4, 1'b0, 1'b0},
      {2'd2, 1'b0, 3'd2, 7'd63,  5'd19, 5'd31, 5'd20, 3'd3, 1'b0, 1'b0},
      {2'd3, 1'b0, 3'd2, 7'd0,   5'd1,  5'd2,  5'd3,  3'd2, 1'b0, 1'b1},
      {2'd0, 1'b0, 3'd0, 7'd4,   5'd1,  5'd31, 5'd3,  3'd2, 1'b0, 1'b1},
      {2'd2, 1'b1, 3'd7, 7'd4,   5'd1,  5'd2,  5'd3,  3'd4, 1'b0, 1'b1},
      {2'd3, 1'b1, 3'd3, 7'd2,   5'd1,  5'd2,  5'd3,  3'd2, 1'b0, 1'b1},
      {2'd2, 1'b1, 3'd3, 7'd63,  5'd0,  5'd31, 5'd31, 3'd4, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] opc, input logic v, input logic [2:0] md,
                                      input logic [6:0] imm, input logic [4:0] rt2,
                                      input logic [4:0] rn, input logic [4:0] rt);
      return {opc, 3'b101, v, md, 1'b1, imm, rt2, rn, rt};
   endfunction

   // memory model: grants after rdy_dly cycles, responds mem_lat cycles later
   initial begin
      rd_ready = 1'b0;
      rd_resp  = 1'b0;
      forever begin
         @(negedge clk);
         if (rd_req && rst_n) begin
            repeat (rdy_dly) @(negedge clk);
            if (nseen < 4) begin
               seen_addr[nseen] = rd_addr;
               seen_size[nseen] = rd_size;
            end
            nseen++;
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            repeat (mem_lat) @(negedge clk);
            rd_resp = 1'b1;
            @(negedge clk);
            rd_resp = 1'b0;
         end
      end
   end

   task automatic run_one(input logic [31:0] insn, input logic [63:0] base, input int lat, input int dly);
      mem_lat = lat;
      rdy_dly = dly;
      nseen   = 0;
      @(negedge clk);
      in_insn  = insn;
      in_base  = base;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R10 actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 ready in reset", 64'(in_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ready", 64'(in_ready), 64'd1);
      chk("R11 no request", 64'(rd_req), 64'd0);
      chk("R11 no done", 64'(done), 64'd0);
      chk("R11 no writeback", 64'(wb_en), 64'd0);
      chk("R11 illegal low", 64'(illegal), 64'd0);
      chk("R11 align low", 64'(align_req), 64'd0);

      for (int i = 0; i < 12; i++) begin
         logic [32:0] e;
         logic [63:0] base, off, first, second;
         int sz;
         e    = TBL[i];
         base = 64'h0000_0040_0000_1000 + 64'(i) * 64'h100;
         sz   = int'(e[4:2]);
         off  = {{57{e[26]}}, e[26:20]} << sz;
         first  = (e[29:27] == 3'd1) ? base : base + off;
         second = first + (64'd1 << sz);
         run_one(mk(e[32:31], e[30], e[29:27], e[26:20], e[19:15], e[14:10], e[9:5]), base, i % 3, i % 2);
         if (e[0]) begin
            chk($sformatf("R3/R4 illegal flag entry %0d", i), 64'(illegal), 64'd1);
            chk($sformatf("R3 no reads entry %0d", i), 64'(nseen), 64'd0);
            chk($sformatf("R3 no writeback entry %0d", i), 64'(wb_en), 64'd0);
            chk($sformatf("R8 no align on illegal entry %0d", i), 64'(align_req), 64'd0);
         end else begin
            chk($sformatf("R3 legal entry %0d", i), 64'(illegal), 64'd0);
            chk($sformatf("R1 first dst entry %0d", i), 64'(dst_first), 64'(e[9:5]));
            chk($sformatf("R1 second dst entry %0d", i), 64'(dst_second), 64'(e[19:15]));
            chk($sformatf("R2 size entry %0d", i), 64'(size_code), 64'(e[4:2]));
            chk($sformatf("R2 signed entry %0d", i), 64'(is_signed), 64'(e[1]));
            chk($sformatf("R2 vector entry %0d", i), 64'(is_vector), 64'(e[30]));
            chk($sformatf("R9 two reads entry %0d", i), 64'(nseen), 64'd2);
            chk($sformatf("R2 read size A entry %0d", i), 64'(seen_size[0]), 64'(e[4:2]));
            chk($sformatf("R2 read size B entry %0d", i), 64'(seen_size[1]), 64'(e[4:2]));
            chk($sformatf("R5 first addr entry %0d", i), addr_first, first);
            chk($sformatf("R5 first read entry %0d", i), seen_addr[0], first);
            chk($sformatf("R6 second addr entry %0d", i), addr_second, second);
            chk($sformatf("R6 second read entry %0d", i), seen_addr[1], second);
            chk($sformatf("R7 wb enable entry %0d", i), 64'(wb_en), 64'(e[29:27] != 3'd2));
            if (e[29:27] != 3'd2)
               chk($sformatf("R7 wb value entry %0d", i), wb_value, base + off);
            chk($sformatf("R8 align entry %0d", i), 64'(align_req), 64'(e[14:10] == 5'd31));
         end
         @(negedge clk);
         chk($sformatf("R10 done single entry %0d", i), 64'(done), 64'd0);
         chk($sformatf("R9 ready again entry %0d", i), 64'(in_ready), 64'd1);
      end

      // R9: a word offered while busy is not taken
      mem_lat = 5;
      rdy_dly = 1;
      nseen   = 0;
      @(negedge clk);
      in_insn  = mk(2'd2, 1'b0, 3'd2, 7'd1, 5'd8, 5'd4, 5'd7);
      in_base  = 64'h2000;
      in_valid = 1'b1;
      @(negedge clk);
      in_insn = mk(2'd0, 1'b0, 3'd2, 7'd1, 5'd26, 5'd4, 5'd25);
      chk("R9 busy not ready", 64'(in_ready), 64'd0);
      while (!done) @(negedge clk);
      chk("R9 busy word ignored", 64'(dst_first), 64'd7);
      chk("R9 busy word ignored size", 64'(size_code), 64'd3);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 no stray accept", 64'(rd_req), 64'd0);

      // R11: reset in mid-flight clears everything
      mem_lat = 6;
      rdy_dly = 0;
      nseen   = 0;
      @(negedge clk);
      in_insn  = mk(2'd2, 1'b0, 3'd3, 7'd2, 5'd9, 5'd31, 5'd11);
      in_base  = 64'h3000;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 align while busy", 64'(align_req), 64'd1);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 mid reset ready", 64'(in_ready), 64'd1);
      chk("R11 mid reset no request", 64'(rd_req), 64'd0);
      chk("R11 mid reset align", 64'(align_req), 64'd0);
      chk("R11 mid reset dst", 64'(dst_first), 64'd0);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      chk("R11 idle after reset", 64'(done), 64'd0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule